// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a programmable device. It follows the sixteen-state test state machine, clocked by the test clock `tck`, and steers the serial test path between a 10-bit instruction register and one of four data registers: a one-bit pass-through stage, a 32-bit identification word, a 32-bit user word and a boundary register with one cell per device pin. Serial data leaves on `tdo`, which changes on the falling edge of `tck` and is enabled only while a register is being shifted.

On the core side the controller samples the pin inputs, can take over the pin output values from the boundary register, can request that every pin go high-impedance, and can emit a one-cycle reconfiguration request without touching any physical pin. Two instructions, the high-impedance one and the clamp one, put the one-bit stage on the serial path while forcing pin behaviour. Any opcode not in the table behaves as the all-ones pass-through instruction. The synchronous reset `rst` acts as the optional test reset.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: After reset the controller is in Test-Logic-Reset with the identification instruction loaded: `tdo_oe`, `hiz_all`, `scan_own` and `reconfig_req` are 0, `pin_drive` equals `core_out`, and a first 32-bit data scan returns `IDCODE_VAL` least significant bit first.
- R2: Five rising `tck` edges with `tms` high bring the state machine to Test-Logic-Reset from any state, which reloads the identification instruction.
- R3: An instruction scan shifts out the capture pattern 10'b0000000001, least significant bit first.
- R4: Opcode 10'b1111111111, and any opcode not listed in R5 to R11, selects the one-bit stage: it captures 0 and delays `tdi` to `tdo` by one `tck`.
- R5: Opcode 10'b0000000110 selects the 32-bit identification word `IDCODE_VAL`, shifted out least significant bit first.
- R6: Opcode 10'b0000000111 selects the 32-bit user word `USERCODE_VAL`, shifted out least significant bit first.
- R7: Opcode 10'b0000000101 selects the boundary register (bit i is pin i, bit 0 shifted out first), captures `pin_in`, loads the shifted pattern into the pin update latch at Update-DR, and leaves `pin_drive` equal to `core_out`.
- R8: Opcode 10'b0000001111 selects the boundary register, captures `pin_in`, sets `scan_own` and drives `pin_drive` from the update latch.
- R9: Opcode 10'b0000001011 selects the one-bit stage and holds `hiz_all` high while it is the current instruction.
- R10: Opcode 10'b0000001010 selects the one-bit stage, sets `scan_own` and holds `pin_drive` at the update latch value regardless of `core_out`.
- R11: Opcode 10'b0000000001 selects the one-bit stage and raises `reconfig_req` for exactly one `tck` cycle after the Update-IR edge.
- R12: `tdo_oe` is high only in Shift-DR and Shift-IR, and `tdo` changes only on the falling edge of `tck`.
- R13: A shifted instruction takes effect only at Update-IR; while it is being shifted the previous instruction's pin control stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pin_in | input | NPINS | Sampled device pin inputs |
| core_out | input | NPINS | Output values from the core logic |
| pin_drive | output | NPINS | Values sent to the output pins |
| scan_own | output | 1 | Pins are driven from the boundary update latch |
| hiz_all | output | 1 | Request to tri-state every I/O pin |
| reconfig_req | output | 1 | One-cycle reconfiguration request |

## Verification
State-machine moves, captures and shifts take place on the rising `tck` edge, while `tdo` follows one half period later; the bench therefore applies `tms`/`tdi` and reads `tdo` one nanosecond after each falling edge, so every bit read is the one about to be shifted out at the next rising edge. Decoded pin controls (`scan_own`, `hiz_all`) and the update latch change on the edge that leaves Update-IR or Update-DR, and `reconfig_req` is high during the one cycle after the Update-IR edge; the bench reads them one nanosecond after that edge and again one cycle later. The falling-edge timing of `tdo` is checked by reading it both just after a rising edge and just after the next falling edge.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_USER, DR_BSR} dr_sel_t;

  localparam logic [IR_W-1:0] OP_BYPASS  = 10'b11_1111_1111;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 10'b00_0000_0101;
  localparam logic [IR_W-1:0] OP_EXTEST  = 10'b00_0000_1111;
  localparam logic [IR_W-1:0] OP_USER    = 10'b00_0000_0111;
  localparam logic [IR_W-1:0] OP_IDENT   = 10'b00_0000_0110;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 10'b00_0000_1011;
  localparam logic [IR_W-1:0] OP_CLAMP   = 10'b00_0000_1010;
  localparam logic [IR_W-1:0] OP_RECONF  = 10'b00_0000_0001;
  localparam logic [IR_W-1:0] IR_CAPTURE = 10'b00_0000_0001;

  typedef struct packed {
    dr_sel_t sel;
    logic    own;
    logic    hiz;
    logic    reconf;
  } ir_dec_t;

  function automatic ir_dec_t decode_op(input logic [IR_W-1:0] op);
    ir_dec_t d;
    d = '{sel: DR_BYP, own: 1'b0, hiz: 1'b0, reconf: 1'b0};
    case (op)
      OP_SAMPLE: d.sel = DR_BSR;
      OP_EXTEST: begin d.sel = DR_BSR; d.own = 1'b1; end
      OP_USER:   d.sel = DR_USER;
      OP_IDENT:  d.sel = DR_ID;
      OP_HIGHZ:  d.hiz = 1'b1;
      OP_CLAMP:  d.own = 1'b1;
      OP_RECONF: d.reconf = 1'b1;
      default:   d.sel = DR_BYP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_TLR;
    else     state <= nxt;
  end

  // checker: run of consecutive high tms samples, saturating at 7
  logic [2:0] ones_run;
  always_ff @(posedge tck) begin
    if (rst)           ones_run <= '0;
    else if (!tms)     ones_run <= '0;
    else if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
  end

  // R2
  tms_reset_chk: assert property (@(posedge tck) disable iff (rst)
    (ones_run >= 3'd5) |-> (state == ST_TLR));
endmodule

// File: rtl/jtag_ir_ctrl.sv
module jtag_ir_ctrl
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_t state,
  output logic       ir_lsb,
  output dr_sel_t    dr_sel,
  output logic       scan_own,
  output logic       hiz_all,
  output logic       reconfig_req
);
  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_q;
  ir_dec_t         dec_q;
  ir_dec_t         dec_new;

  assign dec_new = decode_op(ir_sh);

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst || state == ST_TLR) begin
      ir_q         <= OP_IDENT;
      dec_q        <= decode_op(OP_IDENT);
      reconfig_req <= 1'b0;
    end else if (state == ST_UPD_IR) begin
      ir_q         <= ir_sh;
      dec_q        <= dec_new;
      reconfig_req <= dec_new.reconf;
    end else begin
      reconfig_req <= 1'b0;
    end
  end

  assign ir_lsb   = ir_sh[0];
  assign dr_sel   = dec_q.sel;
  assign scan_own = dec_q.own;
  assign hiz_all  = dec_q.hiz;

  // R13
  ir_hold_chk: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE));

  // R11
  pulse_once_chk: assert property (@(posedge tck) disable iff (rst)
    reconfig_req |=> !reconfig_req);
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
  import jtag_tap_pkg::*;
#(
  parameter int          NPINS        = 8,
  parameter int          WORD_W       = 32,
  parameter logic [31:0] IDCODE_VAL   = 32'h1234_5093,
  parameter logic [31:0] USERCODE_VAL = 32'hCAFE_0001
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             tdi,
  input  tap_state_t       state,
  input  dr_sel_t          dr_sel,
  input  logic             scan_own,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] core_out,
  output logic             dr_lsb,
  output logic [NPINS-1:0] pin_drive
);
  logic              byp_q;
  logic [WORD_W-1:0] word_sh;
  logic [NPINS-1:0]  bsr_sh;
  logic [NPINS-1:0]  bsr_upd;

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q   <= 1'b0;
      word_sh <= '0;
      bsr_sh  <= '0;
    end else if (state == ST_CAP_DR) begin
      case (dr_sel)
        DR_BYP:  byp_q   <= 1'b0;
        DR_ID:   word_sh <= IDCODE_VAL[WORD_W-1:0];
        DR_USER: word_sh <= USERCODE_VAL[WORD_W-1:0];
        DR_BSR:  bsr_sh  <= pin_in;
        default: byp_q   <= 1'b0;
      endcase
    end else if (state == ST_SH_DR) begin
      case (dr_sel)
        DR_BYP:  byp_q   <= tdi;
        DR_BSR:  bsr_sh  <= {tdi, bsr_sh[NPINS-1:1]};
        default: word_sh <= {tdi, word_sh[WORD_W-1:1]};
      endcase
    end
  end

  always_ff @(posedge tck) begin
    if (rst)                                          bsr_upd <= '0;
    else if (state == ST_UPD_DR && dr_sel == DR_BSR) bsr_upd <= bsr_sh;
  end

  always_comb begin
    case (dr_sel)
      DR_BYP:  dr_lsb = byp_q;
      DR_BSR:  dr_lsb = bsr_sh[0];
      default: dr_lsb = word_sh[0];
    endcase
  end

  assign pin_drive = scan_own ? bsr_upd : core_out;

  // R10
  clamp_hold_chk: assert property (@(posedge tck) disable iff (rst)
    (scan_own && !(state == ST_UPD_DR && dr_sel == DR_BSR)) |=> $stable(bsr_upd));

  // R4
  byp_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && dr_sel == DR_BYP) |=> !byp_q);
endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int          NPINS        = 8,
  parameter logic [31:0] IDCODE_VAL   = 32'h1234_5093,
  parameter logic [31:0] USERCODE_VAL = 32'hCAFE_0001
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] core_out,
  output logic [NPINS-1:0] pin_drive,
  output logic             scan_own,
  output logic             hiz_all,
  output logic             reconfig_req
);
  localparam int WORD_W = 32;

  tap_state_t state;
  dr_sel_t    dr_sel;
  logic       ir_lsb;
  logic       dr_lsb;

  jtag_tap_fsm u_fsm (
    .tck(tck), .rst(rst), .tms(tms), .state(state)
  );

  jtag_ir_ctrl u_ir (
    .tck(tck), .rst(rst), .tdi(tdi), .state(state),
    .ir_lsb(ir_lsb), .dr_sel(dr_sel), .scan_own(scan_own),
    .hiz_all(hiz_all), .reconfig_req(reconfig_req)
  );

  jtag_dr_bank #(
    .NPINS(NPINS), .WORD_W(WORD_W),
    .IDCODE_VAL(IDCODE_VAL), .USERCODE_VAL(USERCODE_VAL)
  ) u_dr (
    .tck(tck), .rst(rst), .tdi(tdi), .state(state), .dr_sel(dr_sel),
    .scan_own(scan_own), .pin_in(pin_in), .core_out(core_out),
    .dr_lsb(dr_lsb), .pin_drive(pin_drive)
  );

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  // R12
  oe_window_chk: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
endmodule

// File: tb/tb_jtag_tap_ctrl.sv
`timescale 1ns/1ps
module tb_jtag_tap_ctrl;
  localparam int NP = 8;
  localparam logic [31:0] IDV = 32'h1234_5093;
  localparam logic [31:0] USV = 32'hCAFE_0001;

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, scan_own, hiz_all, reconfig_req;
  logic [NP-1:0] pin_in = '0, core_out = '0, pin_drive;
  int total = 0, bad = 0;

  always #4 tck = ~tck;

  jtag_tap_ctrl #(.NPINS(NP), .IDCODE_VAL(IDV), .USERCODE_VAL(USV)) dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .core_out(core_out), .pin_drive(pin_drive),
    .scan_own(scan_own), .hiz_all(hiz_all), .reconfig_req(reconfig_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    tms = m; tdi = d; o = tdo;
    @(posedge tck);
  endtask

  task automatic to_reset();
    logic b;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
  endtask

  task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
    logic b;
    step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int i = 0; i < 10; i++) begin step(i == 9, op[i], b); cap[i] = b; end
    step(1, 0, b); step(0, 0, b);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic b;
    dout = '0;
    step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int i = 0; i < n; i++) begin step(i == n - 1, din[i], b); dout[i] = b; end
    step(1, 0, b); step(0, 0, b);
  endtask

  function automatic logic [31:0] exp_byp(input logic [31:0] d, input int n);
    logic [31:0] r;
    r = (d << 1) & ((n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1));
    return r;
  endfunction

  function automatic bit listed(input logic [9:0] op);
    return op == 10'h3FF || op == 10'h005 || op == 10'h00F || op == 10'h007 ||
           op == 10'h006 || op == 10'h00B || op == 10'h00A || op == 10'h001;
  endfunction

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] cap;
    logic [31:0] dout, d;
    logic b, a;
    void'($urandom(32'd1357));
    core_out = 8'h3C;
    repeat (3) @(posedge tck);
    @(negedge tck); #1; rst = 1'b0;
    @(negedge tck); #2;
    // R1 reset state
    chk("R1 oe", tdo_oe, 0); chk("R1 hiz", hiz_all, 0);
    chk("R1 own", scan_own, 0); chk("R1 reconf", reconfig_req, 0);
    chk("R1 pins", pin_drive, core_out);
    step(0, 0, b);
    scan_dr(32, 32'h0, dout); chk("R1 idcode after reset", dout, IDV);

    // R3 capture pattern, R6 user word
    load_ir(10'h007, cap); chk("R3 ir capture", cap, 10'b0000000001);
    scan_dr(32, 32'h0, dout); chk("R6 usercode", dout, USV);
    // R5
    load_ir(10'h006, cap); scan_dr(32, 32'h0, dout); chk("R5 idcode", dout, IDV);

    // R4 bypass, R12 timing
    load_ir(10'h3FF, cap);
    d = 32'hA5; scan_dr(8, d, dout); chk("R4 bypass", dout, exp_byp(d, 8));
    step(1, 0, b); step(0, 0, b); step(0, 0, b);     // into Shift-DR
    step(0, 0, b); step(0, 1, a);                    // a: bit held before the 1 enters
    #1; chk("R12 oe in shift", tdo_oe, 1);
    chk("R12 tdo held at rise", tdo, a);
    @(negedge tck); #1; chk("R12 tdo at fall", tdo, 1);
    step(1, 0, b); step(1, 0, b); step(0, 0, b);
    #1; chk("R12 oe idle", tdo_oe, 0);

    // R2 from mid-scan
    load_ir(10'h007, cap);
    step(1, 0, b); step(0, 0, b); step(0, 0, b); step(0, 1, b);
    to_reset();
    scan_dr(32, 32'h0, dout); chk("R2 tms reset reloads id", dout, IDV);

    // R7 sample/preload
    load_ir(10'h005, cap);
    pin_in = 8'h96; core_out = 8'h11;
    scan_dr(NP, 32'h5A, dout); chk("R7 capture", dout, 32'h96);
    #1; chk("R7 pins from core", pin_drive, 8'h11); chk("R7 own", scan_own, 0);

    // R8 extest
    load_ir(10'h00F, cap);
    #1; chk("R8 own", scan_own, 1); chk("R8 preload driven", pin_drive, 8'h5A);
    pin_in = 8'hE1;
    scan_dr(NP, 32'hC3, dout); chk("R8 capture", dout, 32'hE1);
    #1; chk("R8 update", pin_drive, 8'hC3);

    // R13 partial instruction shift keeps extest control
    step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int i = 0; i < 10; i++) step(i == 9, 1'b1, b);
    #1; chk("R13 own during shift", scan_own, 1);
    step(1, 0, b); step(0, 0, b);
    #1; chk("R13 own after update", scan_own, 0);

    // R10 clamp
    load_ir(10'h00A, cap);
    core_out = 8'h0F; #1;
    chk("R10 own", scan_own, 1); chk("R10 hold", pin_drive, 8'hC3);
    d = 32'h3B; scan_dr(6, d, dout); chk("R10 bypass", dout, exp_byp(d, 6));
    #1; chk("R10 hold after scan", pin_drive, 8'hC3);

    // R9 highz
    load_ir(10'h00B, cap);
    #1; chk("R9 hiz", hiz_all, 1);
    d = 32'h2D; scan_dr(7, d, dout); chk("R9 bypass", dout, exp_byp(d, 7));
    #1; chk("R9 hiz held", hiz_all, 1);
    load_ir(10'h3FF, cap); #1; chk("R9 hiz off", hiz_all, 0);

    // R11 reconfiguration pulse
    load_ir(10'h001, cap);
    #1; chk("R11 pulse high", reconfig_req, 1);
    @(posedge tck); #1; chk("R11 pulse low", reconfig_req, 0);
    d = 32'h1F; scan_dr(5, d, dout); chk("R11 bypass", dout, exp_byp(d, 5));
    #1; chk("R11 no repeat", reconfig_req, 0);

    // random: unlisted opcodes behave as bypass (R4), sample capture (R7)
    for (int k = 0; k < 12; k++) begin
      logic [9:0] op;
      op = 10'($urandom);
      if (listed(op)) op = 10'h2A0;
      load_ir(op, cap);
      d = $urandom; scan_dr(16, d, dout);
      chk("R4 unlisted bypass", dout, exp_byp(d, 16));
      load_ir(10'h005, cap);
      pin_in = 8'($urandom);
      scan_dr(NP, $urandom, dout);
      chk("R7 random capture", dout, {24'h0, pin_in});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule